// File: doc/BRIEF.md
# Sync Source Selector with Clamp Pulse Generator

This block receives two already-shaped sync streams: one from a composite or horizontal sync input, and one sliced from sync carried on the green video channel. Each stream arrives with a presence flag. The block picks one stream as the horizontal drive source by fixed priority, with composite/H ranked above green. It drives a true and an inverted horizontal drive output, and it passes the selected stream out as a plain composite.

The block also produces a clamp pulse. The pulse width is set in clock cycles, and it starts on an edge chosen by a two-bit mode input and by which sources are present. A gate input, together with a vertical-interval flag from the vertical separator, decides whether horizontal drive pulses pass while the vertical sync interval is active. The block registers every input once and every output once, so an edge reaches the outputs two clock cycles later. At 50 MHz that is 40 ns, well under the 350 ns limit.

Top module: `sync_select_clamp`

## Requirements
- R1: When compPresent and greenPresent are both 1, hdPos and selSync follow compSync and ignore greenSync.
- R2: When only greenPresent is 1, hdPos and selSync follow greenSync.
- R3: When neither presence flag is 1, hdPos, selSync and clampOut stay 0 and hdNeg stays 1, whatever pulses arrive. After reset the outputs are in this same state.
- R4: With clampMode 2'b00 or 2'b01, or with the unused code 2'b11, the clamp pulse starts on the falling edge of the selected source. That source is composite/H if it is present, and green otherwise.
- R5: With clampMode 2'b10 and only green present, the clamp pulse starts on the falling edge of greenSync.
- R6: With clampMode 2'b10 and composite/H present, with or without green, the clamp pulse starts on the rising edge of compSync.
- R7: clampOut stays high for exactly clampLen clock cycles. A clampLen of 0 gives no pulse.
- R8: A clamp trigger that arrives while a clamp pulse is active is ignored. The active pulse is neither restarted nor lengthened.
- R9: When vInterval is 1 and gateEn is 0, hdPos is held at 0 and hdNeg at 1. When gateEn is 1, or vInterval is 0, pulses pass. selSync is never gated.
- R10: An input edge reaches hdPos and selSync after two rising clock edges, and a clamp trigger edge raises clampOut after the same two edges.
- R11: hdNeg is always the complement of hdPos.
- R12: With parameter GATE_TIE_HIGH set to 1, the gateEn pin is ignored and treated as high. This models an unconnected gate input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| compSync | input | 1 | Shaped composite/H sync, high during sync |
| compPresent | input | 1 | Composite/H source detected |
| greenSync | input | 1 | Shaped sync from green channel, high during sync |
| greenPresent | input | 1 | Green sync source detected |
| clampMode | input | 2 | Clamp position rule: 00 low, 01 mid, 10 high, 11 as mid |
| clampLen | input | LEN_W | Clamp width in clock cycles |
| gateEn | input | 1 | 1 passes HD pulses during the vertical interval |
| vInterval | input | 1 | Vertical sync interval active |
| hdPos | output | 1 | Horizontal drive, positive pulse |
| hdNeg | output | 1 | Horizontal drive, negative pulse |
| clampOut | output | 1 | Clamp pulse |
| selSync | output | 1 | Selected composite sync, ungated |

## Verification
The assertions assume that the presence flags, clampMode, clampLen and the gate inputs change slowly compared with the sync pulses. They also assume that clampLen is not changed while a clamp pulse is running. The stimulus sets these controls between scenarios, while no pulse is in flight, and drives sync pulses only after the controls have settled. The sync pulses themselves are clean single-cycle-resolution levels, since shaping happens upstream.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_MID  = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_RSVD = 2'b11
  } clampMode_e;

  // registered view of the inputs handed from datapath to control
  typedef struct packed {
    logic       compQ;
    logic       compD;
    logic       greenQ;
    logic       greenD;
    logic       compPresQ;
    logic       greenPresQ;
    logic       gateQ;
    logic       vIntQ;
    clampMode_e modeQ;
  } obs_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic selComp;
    logic selGreen;
    logic passHd;
    logic clampTrig;
  } strobe_t;

endpackage

// File: rtl/sync_sel_ctrl.sv
module sync_sel_ctrl
  import sync_sel_pkg::*;
(
  input  obs_t    obs,
  output strobe_t strobe
);

  logic compRise, compFall, greenFall;

  always_comb begin
    compRise  = obs.compQ & ~obs.compD;
    compFall  = ~obs.compQ & obs.compD;
    greenFall = ~obs.greenQ & obs.greenD;

    strobe.selComp  = obs.compPresQ;
    strobe.selGreen = obs.greenPresQ & ~obs.compPresQ;
    strobe.passHd   = obs.gateQ | ~obs.vIntQ;

    if (obs.modeQ == MODE_HIGH) begin
      // composite present: leading edge; green alone: trailing edge
      strobe.clampTrig = obs.compPresQ ? compRise : (obs.greenPresQ & greenFall);
    end else begin
      // trailing edge of the higher-priority present source
      strobe.clampTrig = obs.compPresQ ? compFall : (obs.greenPresQ & greenFall);
    end
  end

endmodule

// File: rtl/sync_sel_dp.sv
module sync_sel_dp
  import sync_sel_pkg::*;
#(
  parameter int LEN_W         = 8,
  parameter bit GATE_TIE_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             compSync,
  input  logic             compPresent,
  input  logic             greenSync,
  input  logic             greenPresent,
  input  logic [1:0]       clampMode,
  input  logic [LEN_W-1:0] clampLen,
  input  logic             gateEn,
  input  logic             vInterval,
  input  strobe_t          strobe,
  output obs_t             obs,
  output logic             hdPos,
  output logic             clampOut,
  output logic             selSync
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             gateEff;
  logic [LEN_W-1:0] clampCnt;
  logic             selLevel;

  generate
    if (GATE_TIE_HIGH) begin : g_gateTied
      assign gateEff = 1'b1;
    end else begin : g_gatePin
      assign gateEff = gateEn;
    end
  endgenerate

  // input stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obs <= '0;
    end else begin
      obs.compQ      <= compSync;
      obs.compD      <= obs.compQ;
      obs.greenQ     <= greenSync;
      obs.greenD     <= obs.greenQ;
      obs.compPresQ  <= compPresent;
      obs.greenPresQ <= greenPresent;
      obs.gateQ      <= gateEff;
      obs.vIntQ      <= vInterval;
      obs.modeQ      <= clampMode_e'(clampMode);
    end
  end

  assign selLevel = (strobe.selComp & obs.compQ) | (strobe.selGreen & obs.greenQ);

  // output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdPos   <= 1'b0;
      selSync <= 1'b0;
    end else begin
      hdPos   <= selLevel & strobe.passHd;
      selSync <= selLevel;
    end
  end

  // clamp width down-counter; triggers are ignored while it runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampCnt <= '0;
    end else if (clampCnt != '0) begin
      clampCnt <= clampCnt - ONE;
    end else if (strobe.clampTrig) begin
      clampCnt <= clampLen;
    end
  end

  assign clampOut = (clampCnt != '0);

  p_no_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!obs.compPresQ && !obs.greenPresQ) |=> !hdPos && !selSync);

  p_comp_priority_r1: assert property (@(posedge clk) disable iff (!rstN)
    obs.compPresQ |=> selSync == $past(obs.compQ));

  p_vgate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (obs.vIntQ && !obs.gateQ) |=> !hdPos);

  p_retrig_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clampCnt != '0) |=> clampCnt == $past(clampCnt) - ONE);

  p_clamp_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clampCnt == '0 && strobe.clampTrig && clampLen != '0) |=> clampOut);

endmodule

// File: rtl/sync_select_clamp.sv
module sync_select_clamp
  import sync_sel_pkg::*;
#(
  parameter int LEN_W         = 8,
  parameter bit GATE_TIE_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             compSync,
  input  logic             compPresent,
  input  logic             greenSync,
  input  logic             greenPresent,
  input  logic [1:0]       clampMode,
  input  logic [LEN_W-1:0] clampLen,
  input  logic             gateEn,
  input  logic             vInterval,
  output logic             hdPos,
  output logic             hdNeg,
  output logic             clampOut,
  output logic             selSync
);

  obs_t    obs;
  strobe_t strobe;

  sync_sel_ctrl ctrl_i (
    .obs    (obs),
    .strobe (strobe)
  );

  sync_sel_dp #(
    .LEN_W         (LEN_W),
    .GATE_TIE_HIGH (GATE_TIE_HIGH)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .compSync     (compSync),
    .compPresent  (compPresent),
    .greenSync    (greenSync),
    .greenPresent (greenPresent),
    .clampMode    (clampMode),
    .clampLen     (clampLen),
    .gateEn       (gateEn),
    .vInterval    (vInterval),
    .strobe       (strobe),
    .obs          (obs),
    .hdPos        (hdPos),
    .clampOut     (clampOut),
    .selSync      (selSync)
  );

  assign hdNeg = ~hdPos;

endmodule

// File: tb/sync_select_clamp_tb_top.sv
module sync_select_clamp_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       compSync = 1'b0, compPresent = 1'b0;
  logic       greenSync = 1'b0, greenPresent = 1'b0;
  logic [1:0] clampMode = 2'b00;
  logic [7:0] clampLen = 8'd10;
  logic       gateEn = 1'b1, vInterval = 1'b0;
  logic       hdPos, hdNeg, clampOut, selSync;
  logic       tHdPos, tHdNeg, tClamp, tSel;

  int errors = 0;
  int checks = 0;

  // results of the last runPulse call
  int firstClamp, clampRun, hdFirst, hdCount, selCount, negBad, tieHdCount;

  always #10 clk = ~clk;

  sync_select_clamp #(.LEN_W(8), .GATE_TIE_HIGH(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .compSync(compSync), .compPresent(compPresent),
    .greenSync(greenSync), .greenPresent(greenPresent), .clampMode(clampMode),
    .clampLen(clampLen), .gateEn(gateEn), .vInterval(vInterval),
    .hdPos(hdPos), .hdNeg(hdNeg), .clampOut(clampOut), .selSync(selSync));

  sync_select_clamp #(.LEN_W(8), .GATE_TIE_HIGH(1'b1)) tie_i (
    .clk(clk), .rstN(rstN), .compSync(compSync), .compPresent(compPresent),
    .greenSync(greenSync), .greenPresent(greenPresent), .clampMode(clampMode),
    .clampLen(clampLen), .gateEn(gateEn), .vInterval(vInterval),
    .hdPos(tHdPos), .hdNeg(tHdNeg), .clampOut(tClamp), .selSync(tSel));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives pulses and records output timing. Index n: value driven at
  // negedge n appears at the outputs when sampled at negedge n+2.
  task automatic runPulse(input int wComp, input int wGreen, input int period,
                          input int nPulses, input int total);
    bit started = 0, ended = 0;
    firstClamp = -1; clampRun = 0; hdFirst = -1; hdCount = 0;
    selCount = 0; negBad = 0; tieHdCount = 0;
    for (int n = 0; n < total; n++) begin
      @(negedge clk);
      if (clampOut) begin
        if (firstClamp < 0) firstClamp = n;
        if (!ended) begin started = 1; clampRun++; end
      end else if (started) ended = 1;
      if (hdPos) begin
        if (hdFirst < 0) hdFirst = n;
        hdCount++;
      end
      if (selSync) selCount++;
      if (tHdPos) tieHdCount++;
      if (hdNeg == hdPos) negBad++;
      compSync  = (n < nPulses * period) && ((n % period) < wComp);
      greenSync = (n < nPulses * period) && ((n % period) < wGreen);
    end
    compSync = 1'b0; greenSync = 1'b0;
  endtask

  task automatic setup(input bit cp, input bit gp, input logic [1:0] m, input logic [7:0] len);
    @(negedge clk);
    compPresent = cp; greenPresent = gp; clampMode = m; clampLen = len;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(hdPos == 1'b0 && selSync == 1'b0, "R3 reset hd/sel", hdPos, 0);
    check(hdNeg == 1'b1, "R3 reset hdNeg", hdNeg, 1);
    check(clampOut == 1'b0, "R3 reset clamp", clampOut, 0);
  endtask

  task automatic testCompOnlyLow();
    setup(1, 0, 2'b00, 8'd10);
    runPulse(5, 0, 100, 1, 40);
    check(hdFirst == 2, "R10 hd latency", hdFirst, 2);
    check(hdCount == 5, "R1 hd width comp", hdCount, 5);
    check(firstClamp == 7, "R4 clamp comp trailing mode low", firstClamp, 7);
    check(clampRun == 10, "R7 clamp width 10", clampRun, 10);
    check(negBad == 0, "R11 hdNeg complement", negBad, 0);
  endtask

  task automatic testBothMid();
    setup(1, 1, 2'b01, 8'd10);
    runPulse(4, 8, 100, 1, 40);
    check(hdCount == 4, "R1 comp priority hd", hdCount, 4);
    check(selCount == 4, "R1 comp priority sel", selCount, 4);
    check(firstClamp == 6, "R4 clamp comp trailing mode mid", firstClamp, 6);
  endtask

  task automatic testGreenMid();
    setup(0, 1, 2'b01, 8'd10);
    runPulse(0, 6, 100, 1, 40);
    check(hdCount == 6, "R2 green hd", hdCount, 6);
    check(selCount == 6, "R2 green sel", selCount, 6);
    check(firstClamp == 8, "R4 clamp green trailing mode mid", firstClamp, 8);
  endtask

  task automatic testRsvdMode();
    setup(1, 0, 2'b11, 8'd10);
    runPulse(5, 0, 100, 1, 40);
    check(firstClamp == 7, "R4 clamp trailing code 11", firstClamp, 7);
  endtask

  task automatic testGreenHigh();
    setup(0, 1, 2'b10, 8'd10);
    runPulse(0, 6, 100, 1, 40);
    check(firstClamp == 8, "R5 clamp green trailing mode high", firstClamp, 8);
  endtask

  task automatic testCompHigh();
    setup(1, 0, 2'b10, 8'd10);
    runPulse(6, 0, 100, 1, 40);
    check(firstClamp == 2, "R6 clamp comp leading", firstClamp, 2);
    setup(1, 1, 2'b10, 8'd10);
    runPulse(6, 3, 100, 1, 40);
    check(firstClamp == 2, "R6 clamp comp leading with green", firstClamp, 2);
  endtask

  task automatic testNoSource();
    setup(0, 0, 2'b00, 8'd10);
    runPulse(5, 5, 100, 1, 40);
    check(hdCount == 0 && selCount == 0, "R3 no source hd/sel", hdCount + selCount, 0);
    check(firstClamp == -1, "R3 no source clamp", firstClamp, -1);
    check(negBad == 0, "R11 hdNeg idle", negBad, 0);
  endtask

  task automatic testRetrigger();
    setup(1, 0, 2'b10, 8'd10);
    runPulse(3, 0, 6, 3, 50);
    check(firstClamp == 2, "R8 first clamp start", firstClamp, 2);
    check(clampRun == 10, "R8 pulse not extended", clampRun, 10);
  endtask

  task automatic testWidths();
    setup(1, 0, 2'b10, 8'd0);
    runPulse(5, 0, 100, 1, 40);
    check(firstClamp == -1, "R7 zero width no clamp", firstClamp, -1);
    setup(1, 0, 2'b10, 8'd25);
    runPulse(5, 0, 100, 1, 50);
    check(clampRun == 25, "R7 clamp width 25", clampRun, 25);
  endtask

  task automatic testGate();
    setup(1, 0, 2'b00, 8'd10);
    gateEn = 1'b0; vInterval = 1'b1;
    repeat (3) @(negedge clk);
    runPulse(5, 0, 100, 1, 30);
    check(hdCount == 0, "R9 hd suppressed in vertical interval", hdCount, 0);
    check(selCount == 5, "R9 sel not gated", selCount, 5);
    check(tieHdCount == 5, "R12 tied gate passes", tieHdCount, 5);
    gateEn = 1'b1;
    repeat (3) @(negedge clk);
    runPulse(5, 0, 100, 1, 30);
    check(hdCount == 5, "R9 hd passes gate high", hdCount, 5);
    gateEn = 1'b0; vInterval = 1'b0;
    repeat (3) @(negedge clk);
    runPulse(5, 0, 100, 1, 30);
    check(hdCount == 5, "R9 hd passes outside interval", hdCount, 5);
    gateEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testCompOnlyLow();
    testBothMid();
    testGreenMid();
    testRsvdMode();
    testGreenHigh();
    testCompHigh();
    testNoSource();
    testRetrigger();
    testWidths();
    testGate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule